// File: doc/BRIEF.md
# Glyph Pattern Store with Cursor Merge

This block keeps sixteen user-drawn glyphs, each eight rows tall and five pixels wide, in a 128-entry by 5-bit pattern RAM. A host side fills the RAM through a 7-bit pattern pointer. Two load commands position the pointer: a partial load sets only the six low bits, and a full load sets all seven. Each host write stores one row and then steps the pointer forward.

A display side presents an 8-bit glyph code and a 3-bit row index. One clock later it gets back five column pixels and a flag. The flag says whether the code selected the user glyph space, which is the case only when the upper four code bits are all zero. The pointer is always visible as a status output.

The last row of every glyph is where the cursor sits. When the cursor is on, that row is shown as the stored pixels OR-ed with a full cursor bar.

Top module: `glyph_ram_ctl`

## Requirements
- R1: After reset the pattern pointer `host_ptr` is 0, `disp_pix` is 0 and `disp_user` is 0.
- R2: A host write stores bits 4:0 of `host_din` at the pointer location. Bits 7:5 of `host_din` have no effect on the stored row.
- R3: Each host write increments the 7-bit pointer on the same clock edge as the store, and the pointer wraps from 127 to 0.
- R4: A partial load copies `host_din[5:0]` into pointer bits 5:0 and leaves pointer bit 6 unchanged. `host_din[7:6]` is ignored.
- R5: A full load copies `host_din[6:0]` into the whole pointer, so pointer bit 6 can be set or cleared this way.
- R6: `host_ptr` shows all 7 pointer bits at all times, including bit 6.
- R7: The display lookup address is {code[3:0], row[2:0]}, with code bits forming address bits 6:3 and row forming bits 2:0. `disp_pix` holds that location's 5 stored bits (bit n = column n, 1 = lit) on the cycle after the code and row are presented.
- R8: When any of `disp_code[7:4]` is 1, `disp_pix` is 0 and `disp_user` is 0 one cycle later. When they are all 0, `disp_user` is 1.
- R9: For a user code with row 7 and `cursor_on`=1, `disp_pix` is the stored row OR 5'b11111. With `cursor_on`=0, or on any row other than 7, the cursor has no effect.
- R10: Host commands issued in the same cycle are ranked full load > partial load > write. A lower-ranked command that loses is ignored: it neither stores nor moves the pointer.
- R11: When a host write and a display lookup hit the same address in the same cycle, the lookup returns the data stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ld_all | input | 1 | Full pointer load from host_din[6:0] |
| host_ld_lo | input | 1 | Partial pointer load from host_din[5:0] |
| host_wr | input | 1 | Store host_din[4:0] at pointer, then increment |
| host_din | input | 8 | Host data / address byte |
| host_ptr | output | 7 | Current pattern pointer (status) |
| disp_code | input | 8 | Glyph code for display lookup |
| disp_row | input | 3 | Row within glyph |
| cursor_on | input | 1 | Cursor present at this cell |
| disp_pix | output | 5 | Column pixels, one cycle after lookup |
| disp_user | output | 1 | Code selected user glyph space |

## Verification
The bench fills every location with rows whose upper data bits are nonzero. A design that stored the whole byte, or that failed to wrap the pointer at 127, would show wrong pixels or a wrong status value. Partial loads are tried with pointer bit 6 both set and clear and with `host_din[6]` set, which exposes a load that overwrites bit 6. Combined commands check the ranking through both the pointer and the untouched RAM contents. A same-address write during a lookup must return the old row, which a write-first RAM would get wrong. Cursor checks cover row 7 against other rows and cursor on against off, and codes with any upper bit set must give blank output.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
   typedef enum logic [1:0] {
      OP_IDLE     = 2'd0,
      OP_WRITE    = 2'd1,
      OP_LOAD_LO  = 2'd2,
      OP_LOAD_ALL = 2'd3
   } host_op_e;
endpackage

// File: rtl/glyph_ptr_ctr.sv
module glyph_ptr_ctr
   import glyph_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int LO_W   = 6,
   parameter int DIN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_all,
   input  logic              ld_lo,
   input  logic              wr,
   input  logic [DIN_W-1:0]  din,
   output logic [ADDR_W-1:0] ptr,
   output logic              wr_en
);
   generate
      if (LO_W >= ADDR_W) begin : g_bad_lo
         $error("LO_W must be narrower than ADDR_W");
      end
      if (DIN_W < ADDR_W) begin : g_bad_din
         $error("DIN_W must cover ADDR_W");
      end
   endgenerate

   host_op_e op;

   always_comb begin
      if (ld_all)     op = OP_LOAD_ALL;
      else if (ld_lo) op = OP_LOAD_LO;
      else if (wr)    op = OP_WRITE;
      else            op = OP_IDLE;
   end

   assign wr_en = (op == OP_WRITE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else begin
         case (op)
            OP_LOAD_ALL: ptr <= din[ADDR_W-1:0];
            OP_LOAD_LO:  ptr <= {ptr[ADDR_W-1:LO_W], din[LO_W-1:0]};
            OP_WRITE:    ptr <= ptr + 1'b1;
            default:     ptr <= ptr;
         endcase
      end
   end

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !ld_all && !ld_lo) |=> (ptr == $past(ptr) + 1'b1)); // R3
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !ld_all && !ld_lo && (&ptr)) |=> (ptr == '0)); // R3
   AST_LO_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_lo && !ld_all) |=> (ptr[ADDR_W-1:LO_W] == $past(ptr[ADDR_W-1:LO_W]))); // R4
   AST_LO_LOADS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_lo && !ld_all) |=> (ptr[LO_W-1:0] == $past(din[LO_W-1:0]))); // R4
   AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_all |=> (ptr == $past(din[ADDR_W-1:0]))); // R5
   AST_RANK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_all || ld_lo) |-> !wr_en); // R10
endmodule

// File: rtl/glyph_store.sv
module glyph_store #(
   parameter int ADDR_W = 7,
   parameter int COL_W  = 5
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [COL_W-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [COL_W-1:0]  rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [COL_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/glyph_fetch.sv
module glyph_fetch #(
   parameter int CODE_W = 8,
   parameter int SLOT_W = 4,
   parameter int ROW_W  = 3,
   parameter int COL_W  = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CODE_W-1:0]         code,
   input  logic [ROW_W-1:0]          row,
   input  logic                      cursor_on,
   output logic [SLOT_W+ROW_W-1:0]   raddr,
   input  logic [COL_W-1:0]          rdata,
   output logic [COL_W-1:0]          pix,
   output logic                      user_sel
);
   generate
      if (SLOT_W >= CODE_W) begin : g_bad_slot
         $error("SLOT_W must be narrower than CODE_W");
      end
   endgenerate

   localparam logic [ROW_W-1:0] CURSOR_ROW = {ROW_W{1'b1}};

   logic sel_d, cur_d, sel_q, cur_q;

   assign raddr = {code[SLOT_W-1:0], row};
   assign sel_d = (code[CODE_W-1:SLOT_W] == '0);
   assign cur_d = cursor_on && (row == CURSOR_ROW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         cur_q <= 1'b0;
      end else begin
         sel_q <= sel_d;
         cur_q <= cur_d;
      end
   end

   genvar c;
   generate
      for (c = 0; c < COL_W; c++) begin : g_col
         assign pix[c] = sel_q & (rdata[c] | cur_q);
      end
   endgenerate

   assign user_sel = sel_q;

   AST_BLANK_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (code[CODE_W-1:SLOT_W] != '0) |=> (pix == '0 && !user_sel)); // R8
   AST_USER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (code[CODE_W-1:SLOT_W] == '0) |=> user_sel); // R8
   AST_CURSOR_BAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_d && cursor_on && row == CURSOR_ROW) |=> (pix == {COL_W{1'b1}})); // R9
endmodule

// File: rtl/glyph_ram_ctl.sv
module glyph_ram_ctl #(
   parameter int CODE_W = 8,
   parameter int SLOT_W = 4,
   parameter int ROW_W  = 3,
   parameter int COL_W  = 5,
   parameter int LO_W   = 6,
   parameter int DIN_W  = 8,
   localparam int ADDR_W = SLOT_W + ROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_ld_all,
   input  logic              host_ld_lo,
   input  logic              host_wr,
   input  logic [DIN_W-1:0]  host_din,
   output logic [ADDR_W-1:0] host_ptr,
   input  logic [CODE_W-1:0] disp_code,
   input  logic [ROW_W-1:0]  disp_row,
   input  logic              cursor_on,
   output logic [COL_W-1:0]  disp_pix,
   output logic              disp_user
);
   generate
      if (COL_W > DIN_W) begin : g_bad_col
         $error("COL_W must fit in DIN_W");
      end
   endgenerate

   logic              wr_en;
   logic [ADDR_W-1:0] raddr;
   logic [COL_W-1:0]  rdata;

   glyph_ptr_ctr #(.ADDR_W(ADDR_W), .LO_W(LO_W), .DIN_W(DIN_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .ld_all(host_ld_all), .ld_lo(host_ld_lo), .wr(host_wr),
      .din(host_din), .ptr(host_ptr), .wr_en(wr_en)
   );

   glyph_store #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_mem (
      .clk(clk), .we(wr_en), .waddr(host_ptr),
      .wdata(host_din[COL_W-1:0]), .raddr(raddr), .rdata(rdata)
   );

   glyph_fetch #(.CODE_W(CODE_W), .SLOT_W(SLOT_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .code(disp_code), .row(disp_row), .cursor_on(cursor_on),
      .raddr(raddr), .rdata(rdata), .pix(disp_pix), .user_sel(disp_user)
   );

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (host_ptr == '0 && disp_pix == '0 && !disp_user)); // R1
endmodule

// File: tb/sim_glyph_ram_ctl.sv
module sim_glyph_ram_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_ld_all = 0, host_ld_lo = 0, host_wr = 0;
   logic [7:0] host_din = '0;
   logic [6:0] host_ptr;
   logic [7:0] disp_code = '0;
   logic [2:0] disp_row = '0;
   logic       cursor_on = 0;
   logic [4:0] disp_pix;
   logic       disp_user;

   int n_cmp = 0, n_bad = 0;
   logic [4:0] model [128];
   bit done = 0;

   always #2 clk = ~clk;

   glyph_ram_ctl u0 (.*);

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      host_ld_all = 0; host_ld_lo = 0; host_wr = 0;
   endtask

   // one host command cycle, checked after the edge
   task automatic host_cmd(bit la, bit ll, bit w, logic [7:0] d);
      @(negedge clk);
      host_ld_all = la; host_ld_lo = ll; host_wr = w; host_din = d;
      @(posedge clk); #1;
      idle();
   endtask

   task automatic lookup(logic [7:0] code, logic [2:0] row, bit cur);
      @(negedge clk);
      disp_code = code; disp_row = row; cursor_on = cur;
      @(posedge clk); #1;
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 ptr", host_ptr, 0);
      chk("R1 pix", disp_pix, 0);
      chk("R1 user", disp_user, 0);
      @(negedge clk); rst_n = 1;
   endtask

   task automatic t_fill();
      host_cmd(1, 0, 0, 8'h00);
      for (int i = 0; i < 128; i++) begin
         logic [4:0] p = 5'((i * 13 + 5) % 32);
         model[i] = p;
         host_cmd(0, 0, 1, {3'b101, p});
         chk("R3 step", host_ptr, (i + 1) % 128);
      end
      chk("R3 wrap", host_ptr, 0);
   endtask

   task automatic t_read();
      for (int c = 0; c < 16; c += 5) begin
         for (int r = 0; r < 8; r += 3) begin
            lookup(8'(c), 3'(r), 0);
            chk("R7/R2 pix", disp_pix, model[c * 8 + r]);
            chk("R8 user", disp_user, 1);
         end
      end
      lookup(8'h0F, 3'd7, 0);
      chk("R7 top cell", disp_pix, model[127]);
   endtask

   task automatic t_foreign();
      lookup(8'h15, 3'd2, 0);
      chk("R8 pix 0x15", disp_pix, 0);
      chk("R8 user 0x15", disp_user, 0);
      lookup(8'h80, 3'd7, 1);
      chk("R8 pix 0x80 cursor", disp_pix, 0);
      chk("R8 user 0x80", disp_user, 0);
      lookup(8'hF0, 3'd0, 0);
      chk("R8 pix 0xF0", disp_pix, 0);
   endtask

   task automatic t_cursor();
      lookup(8'h05, 3'd7, 1);
      chk("R9 cursor row", disp_pix, 5'h1F);
      lookup(8'h05, 3'd7, 0);
      chk("R9 cursor off", disp_pix, model[5 * 8 + 7]);
      lookup(8'h03, 3'd2, 1);
      chk("R9 other row", disp_pix, model[3 * 8 + 2]);
   endtask

   task automatic t_loads();
      host_cmd(1, 0, 0, 8'h40);
      chk("R5 bit6 set", host_ptr, 7'h40);
      chk("R6 status bit6", host_ptr[6], 1);
      host_cmd(0, 1, 0, 8'hFF);
      chk("R4 keep bit6", host_ptr, 7'h7F);
      host_cmd(1, 0, 0, 8'h85);
      chk("R5 clear bit6", host_ptr, 7'h05);
      host_cmd(0, 1, 0, 8'h55);
      chk("R4 din6 ignored", host_ptr, 7'h15);
      host_cmd(0, 0, 1, 8'h1A); model[7'h15] = 5'h1A;
      lookup(8'h02, 3'd5, 0);
      chk("R2 store after load", disp_pix, 5'h1A);
      chk("R3 step after load", host_ptr, 7'h16);
   endtask

   task automatic t_rank();
      host_cmd(1, 1, 1, 8'h31);
      chk("R10 full wins", host_ptr, 7'h31);
      lookup(8'h02, 3'd6, 0);
      chk("R10 no store", disp_pix, model[7'h16]);
      host_cmd(0, 1, 1, 8'h4A);
      chk("R10 partial wins", host_ptr, 7'h0A);
      lookup(8'h06, 3'd1, 0);
      chk("R10 no store 2", disp_pix, model[7'h31]);
   endtask

   task automatic t_collide();
      host_cmd(1, 0, 0, 8'h3B);
      @(negedge clk);
      host_wr = 1; host_din = 8'h0E;
      disp_code = 8'h07; disp_row = 3'd3; cursor_on = 0;
      @(posedge clk); #1;
      idle();
      chk("R11 old data", disp_pix, model[7'h3B]);
      model[7'h3B] = 5'h0E;
      lookup(8'h07, 3'd3, 0);
      chk("R11 new data", disp_pix, 5'h0E);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_fill();
      t_read();
      t_foreign();
      t_cursor();
      t_loads();
      t_rank();
      t_collide();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule